// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This unit decides whether a control-flow condition holds. Each cycle it may take a decoded condition code, two register operands (`src_a` and `src_b`, both 64 bits by default), a sign-extended immediate and a requested destination index. When the valid strobe is high, it samples these inputs and evaluates them. One cycle later it presents registered flags:
- whether a branch is taken,
- whether a trap is requested,
- whether a conditional move may write,
- whether the delay-slot instruction must be squashed,
- whether a return address must be written, and to which register.

All comparisons share one datapath. The second operand is chosen from `src_b`, zero, or the immediate. A single subtract and an equality test then give equal, signed-less-than and unsigned-less-than. Target address arithmetic, pipeline flush and exception entry belong to other blocks.

Top module: `cond_eval`

## Requirements
- R1: Codes BR_EQ (1) and BR_NE (2) take the branch when `src_a` equals, or does not equal, `src_b`.
- R2: Codes BR_GEZ (3), BR_GTZ (4), BR_LEZ (5) and BR_LTZ (6) compare `src_a` as a signed value against zero.
- R3: Codes BR_GEZ_LNK (7) and BR_LTZ_LNK (8) behave like BR_GEZ and BR_LTZ. They also assert `link_en` with `link_idx` = 31, whether or not the branch is taken.
- R4: Code JMP_REG_LNK (9) is always taken and asserts `link_en`. `link_idx` is `dest_idx`, or 31 when `dest_idx` is 0.
- R5: Trap codes TR_EQ (10), TR_NE (11), TR_GE (12), TR_GEU (13), TR_LT (14) and TR_LTU (15) compare `src_a` against `src_b` and assert `trap_req` when the relation holds. The GE and LT forms are signed; the U forms are unsigned.
- R6: Codes 16 to 21 apply the same six relations as R5, in the same order, but compare against `imm`. For the unsigned forms, `imm` is read as an unsigned 64-bit value.
- R7: Code MOV_NZ (22) asserts `move_en` when `src_b` is non-zero. Code MOV_Z (23) asserts it when `src_b` is zero.
- R8: Input bit `likely` marks a branch as the likely form. For a branch code (1 to 8) with `likely` = 1 and a false condition, `annul` = 1. `annul` is never asserted for a normal branch, nor for any non-branch code.
- R9: All outputs are registered. Inputs sampled with `in_valid` = 1 appear on the outputs at the next clock edge, with `out_valid` = 1.
- R10: When `in_valid` = 0, or the code is NOP (0) or undefined (24 to 31), the next cycle shows all flags at 0, `link_idx` at 0, and `out_valid` equal to the sampled `in_valid`. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies the inputs this cycle |
| code | input | 5 | Decoded condition code |
| likely | input | 1 | Likely form of a branch |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 64 | Sign-extended immediate |
| dest_idx | input | 5 | Requested link register (0 means default) |
| out_valid | output | 1 | Outputs correspond to a sampled valid input |
| taken | output | 1 | Branch or jump condition holds |
| trap_req | output | 1 | Trap condition holds |
| move_en | output | 1 | Conditional move may write |
| annul | output | 1 | Squash the delay-slot instruction |
| link_en | output | 1 | Write a return address |
| link_idx | output | 5 | Register that receives the return address |

## Verification
A bad operand select or a wrong carry in the shared subtract shows up one cycle after the strobe. It appears as a wrong `taken`, `trap_req` or `move_en`, most visibly at the boundaries: equal operands, values on either side of zero, and operands that differ only in the sign bit. There, the signed and unsigned orderings disagree. A bad class decode shows up on the same cycle as a flag raised for the wrong family of codes, for example `annul` on a trap. A stale result register shows up as flags that linger after `in_valid` drops.

// File: rtl/cond_eval_pkg.sv
// Package: condition codes and shared types for the condition evaluator.
package cond_eval_pkg;
    localparam int CODE_W = 5;
    localparam int IDX_W  = 5;

    typedef enum logic [CODE_W-1:0] {
        C_NOP        = 5'd0,
        C_BR_EQ      = 5'd1,
        C_BR_NE      = 5'd2,
        C_BR_GEZ     = 5'd3,
        C_BR_GTZ     = 5'd4,
        C_BR_LEZ     = 5'd5,
        C_BR_LTZ     = 5'd6,
        C_BR_GEZ_LNK = 5'd7,
        C_BR_LTZ_LNK = 5'd8,
        C_JR_LNK     = 5'd9,
        C_TR_EQ      = 5'd10,
        C_TR_NE      = 5'd11,
        C_TR_GE      = 5'd12,
        C_TR_GEU     = 5'd13,
        C_TR_LT      = 5'd14,
        C_TR_LTU     = 5'd15,
        C_TI_EQ      = 5'd16,
        C_TI_NE      = 5'd17,
        C_TI_GE      = 5'd18,
        C_TI_GEU     = 5'd19,
        C_TI_LT      = 5'd20,
        C_TI_LTU     = 5'd21,
        C_MOV_NZ     = 5'd22,
        C_MOV_Z      = 5'd23
    } cond_code_e;

    // Second operand of the shared comparator
    typedef enum logic [1:0] { OPB_REG, OPB_ZERO, OPB_IMM } opb_sel_e;

    // Relation the decoded instruction asks of the comparator
    typedef enum logic [2:0] { REL_EQ, REL_NE, REL_GE, REL_GT, REL_LE, REL_LT, REL_TRUE } rel_e;

    // Instruction family
    typedef enum logic [2:0] { K_NONE, K_BRANCH, K_JUMP, K_TRAP, K_MOVE } kind_e;

    typedef struct packed {
        kind_e    kind;
        opb_sel_e opb;
        rel_e     rel;
        logic     uns;
        logic     link31;
        logic     link_rd;
    } dec_t;
endpackage

// File: rtl/cond_decode.sv
// Module: cond_decode
// Turns a condition code into comparator controls and an instruction family.
// Assumes undefined codes decode to K_NONE so that no flag is raised.
module cond_decode
    import cond_eval_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output dec_t              dec
);
    // Decode table: family, operand select, relation, signedness, link kind
    always_comb begin
        dec = '{kind: K_NONE, opb: OPB_REG, rel: REL_TRUE, uns: 1'b0,
                link31: 1'b0, link_rd: 1'b0};
        case (code)
            C_BR_EQ:      begin dec.kind = K_BRANCH; dec.rel = REL_EQ; end
            C_BR_NE:      begin dec.kind = K_BRANCH; dec.rel = REL_NE; end
            C_BR_GEZ:     begin dec.kind = K_BRANCH; dec.opb = OPB_ZERO; dec.rel = REL_GE; end
            C_BR_GTZ:     begin dec.kind = K_BRANCH; dec.opb = OPB_ZERO; dec.rel = REL_GT; end
            C_BR_LEZ:     begin dec.kind = K_BRANCH; dec.opb = OPB_ZERO; dec.rel = REL_LE; end
            C_BR_LTZ:     begin dec.kind = K_BRANCH; dec.opb = OPB_ZERO; dec.rel = REL_LT; end
            C_BR_GEZ_LNK: begin dec.kind = K_BRANCH; dec.opb = OPB_ZERO; dec.rel = REL_GE; dec.link31 = 1'b1; end
            C_BR_LTZ_LNK: begin dec.kind = K_BRANCH; dec.opb = OPB_ZERO; dec.rel = REL_LT; dec.link31 = 1'b1; end
            C_JR_LNK:     begin dec.kind = K_JUMP;   dec.rel = REL_TRUE; dec.link_rd = 1'b1; end
            C_TR_EQ:      begin dec.kind = K_TRAP; dec.rel = REL_EQ; end
            C_TR_NE:      begin dec.kind = K_TRAP; dec.rel = REL_NE; end
            C_TR_GE:      begin dec.kind = K_TRAP; dec.rel = REL_GE; end
            C_TR_GEU:     begin dec.kind = K_TRAP; dec.rel = REL_GE; dec.uns = 1'b1; end
            C_TR_LT:      begin dec.kind = K_TRAP; dec.rel = REL_LT; end
            C_TR_LTU:     begin dec.kind = K_TRAP; dec.rel = REL_LT; dec.uns = 1'b1; end
            C_TI_EQ:      begin dec.kind = K_TRAP; dec.opb = OPB_IMM; dec.rel = REL_EQ; end
            C_TI_NE:      begin dec.kind = K_TRAP; dec.opb = OPB_IMM; dec.rel = REL_NE; end
            C_TI_GE:      begin dec.kind = K_TRAP; dec.opb = OPB_IMM; dec.rel = REL_GE; end
            C_TI_GEU:     begin dec.kind = K_TRAP; dec.opb = OPB_IMM; dec.rel = REL_GE; dec.uns = 1'b1; end
            C_TI_LT:      begin dec.kind = K_TRAP; dec.opb = OPB_IMM; dec.rel = REL_LT; end
            C_TI_LTU:     begin dec.kind = K_TRAP; dec.opb = OPB_IMM; dec.rel = REL_LT; dec.uns = 1'b1; end
            // Conditional moves test src_b against zero; src_b is steered into the A side
            C_MOV_NZ:     begin dec.kind = K_MOVE; dec.opb = OPB_ZERO; dec.rel = REL_NE; end
            C_MOV_Z:      begin dec.kind = K_MOVE; dec.opb = OPB_ZERO; dec.rel = REL_EQ; end
            default:      ;
        endcase
    end
endmodule

// File: rtl/cond_compare.sv
// Module: cond_compare
// One shared comparator: a single subtract gives equal, signed-less and unsigned-less.
// Assumes both operands are WIDTH bits; the immediate arrives already sign-extended.
module cond_compare #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             eq,
    output logic             lt_s,
    output logic             lt_u
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] diff;

    // Subtract with an extra bit so the borrow gives unsigned ordering
    always_comb begin
        diff = {1'b0, op_a} - {1'b0, op_b};
        eq   = (op_a == op_b);
        lt_u = diff[WIDTH];
        // Signed: differing signs decide directly, otherwise the unsigned borrow decides
        lt_s = (op_a[WIDTH-1] != op_b[WIDTH-1]) ? op_a[WIDTH-1] : diff[WIDTH];
    end
endmodule

// File: rtl/cond_eval.sv
// Module: cond_eval (top)
// Registered condition evaluator for branches, traps, conditional moves and links.
// Assumes decoded codes from cond_eval_pkg; outputs follow the strobed inputs by one cycle.
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int WIDTH    = 64,
    parameter int LINK_REG = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CODE_W-1:0]    code,
    input  logic                 likely,
    input  logic [WIDTH-1:0]     src_a,
    input  logic [WIDTH-1:0]     src_b,
    input  logic [WIDTH-1:0]     imm,
    input  logic [IDX_W-1:0]     dest_idx,
    output logic                 out_valid,
    output logic                 taken,
    output logic                 trap_req,
    output logic                 move_en,
    output logic                 annul,
    output logic                 link_en,
    output logic [IDX_W-1:0]     link_idx
);
    localparam logic [IDX_W-1:0] LINK_DEF = IDX_W'(LINK_REG);

    dec_t             dec;
    logic [WIDTH-1:0] cmp_a, cmp_b;
    logic             eq, lt_s, lt_u, lt, hold;
    logic             n_taken, n_trap, n_move, n_annul, n_link;
    logic [IDX_W-1:0] n_idx;

    cond_decode u_dec (.code(code), .dec(dec));

    // Operand steering into the single comparator
    always_comb begin
        cmp_a = (dec.kind == K_MOVE) ? src_b : src_a;
        case (dec.opb)
            OPB_ZERO: cmp_b = '0;
            OPB_IMM:  cmp_b = imm;
            default:  cmp_b = src_b;
        endcase
    end

    cond_compare #(.WIDTH(WIDTH)) u_cmp (
        .op_a(cmp_a), .op_b(cmp_b), .eq(eq), .lt_s(lt_s), .lt_u(lt_u)
    );

    // Relation resolution from the three comparator results
    always_comb begin
        lt = dec.uns ? lt_u : lt_s;
        case (dec.rel)
            REL_EQ:  hold = eq;
            REL_NE:  hold = !eq;
            REL_GE:  hold = !lt;
            REL_GT:  hold = !lt && !eq;
            REL_LE:  hold = lt || eq;
            REL_LT:  hold = lt;
            default: hold = 1'b1;
        endcase
    end

    // Flag formation per family, gated by the valid strobe
    always_comb begin
        n_taken = in_valid && (((dec.kind == K_BRANCH) && hold) || (dec.kind == K_JUMP));
        n_trap  = in_valid && (dec.kind == K_TRAP) && hold;
        n_move  = in_valid && (dec.kind == K_MOVE) && hold;
        n_annul = in_valid && (dec.kind == K_BRANCH) && likely && !hold;
        n_link  = in_valid && (dec.link31 || dec.link_rd);
        n_idx   = '0;
        if (n_link)
            n_idx = (dec.link_rd && dest_idx != '0) ? dest_idx : LINK_DEF;
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            trap_req  <= 1'b0;
            move_en   <= 1'b0;
            annul     <= 1'b0;
            link_en   <= 1'b0;
            link_idx  <= '0;
        end else begin
            out_valid <= in_valid;
            taken     <= n_taken;
            trap_req  <= n_trap;
            move_en   <= n_move;
            annul     <= n_annul;
            link_en   <= n_link;
            link_idx  <= n_idx;
        end
    end
endmodule

// File: rtl/cond_eval_chk.sv
// Module: cond_eval_chk
// Port-level properties of cond_eval, attached by bind.
module cond_eval_chk
    import cond_eval_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [4:0]       code,
    input logic             likely,
    input logic [4:0]       dest_idx,
    input logic             out_valid,
    input logic             taken,
    input logic             trap_req,
    input logic             move_en,
    input logic             annul,
    input logic             link_en,
    input logic [4:0]       link_idx
);
    // R9: out_valid follows the strobe by one cycle
    p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> out_valid == $past(in_valid));

    // R10: no flag without a sampled valid input
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !taken && !trap_req && !move_en && !annul && !link_en);

    // R8: a normal branch never annuls
    p_no_annul_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !likely |=> !annul);

    // R8: annul and taken are exclusive
    p_annul_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> !taken);

    // R3: linking branches always point at register 31
    p_link31_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (code == 5'd7 || code == 5'd8) |=> link_en && link_idx == 5'd31);

    // R4: register jump-and-link is always taken
    p_jump_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && code == 5'd9 |=> taken && link_en);

    // R10: at most one of the family flags
    p_one_family_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_req, move_en, taken}));
endmodule

bind cond_eval cond_eval_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code(code), .likely(likely),
    .dest_idx(dest_idx), .out_valid(out_valid), .taken(taken), .trap_req(trap_req),
    .move_en(move_en), .annul(annul), .link_en(link_en), .link_idx(link_idx)
);

// File: tb/cond_eval_tb.sv
// Bench: sweeps every code over a grid of boundary operands, with expectations from the requirements.
module cond_eval_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic [4:0]  code = 0;
    logic        likely = 0;
    logic [63:0] src_a = 0, src_b = 0, imm = 0;
    logic [4:0]  dest_idx = 0;
    logic        out_valid, taken, trap_req, move_en, annul, link_en;
    logic [4:0]  link_idx;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cond_eval u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code(code), .likely(likely),
        .src_a(src_a), .src_b(src_b), .imm(imm), .dest_idx(dest_idx),
        .out_valid(out_valid), .taken(taken), .trap_req(trap_req), .move_en(move_en),
        .annul(annul), .link_en(link_en), .link_idx(link_idx)
    );

    logic [63:0] vals [8];
    initial begin
        vals[0] = 64'd0;
        vals[1] = 64'd1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[4] = 64'h8000_0000_0000_0000;
        vals[5] = 64'd5;
        vals[6] = 64'hFFFF_FFFF_FFFF_FFFB;
        vals[7] = 64'h0000_0001_0000_0000;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s code=%0d a=%h b=%h imm=%h lk=%0b act=%h exp=%h",
                     req, code, src_a, src_b, imm, likely, act, exp_v);
        end
    endtask

    // Reference relation from the requirement wording
    function automatic logic rel(input int r, input logic [63:0] a, input logic [63:0] b, input logic u);
        logic lt;
        lt = u ? (a < b) : ($signed(a) < $signed(b));
        case (r)
            0: rel = (a == b);
            1: rel = (a != b);
            2: rel = !lt;
            3: rel = lt;
            default: rel = 1'b0;
        endcase
    endfunction

    // Apply one strobed input and check the registered outputs after the next edge
    task automatic apply(input logic v, input int c, input logic lk,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] im, input logic [4:0] di);
        logic e_tk, e_tr, e_mv, e_an, e_ln;
        logic [4:0] e_ix;
        string rq;
        @(negedge clk);
        in_valid = v; code = 5'(c); likely = lk; src_a = a; src_b = b; imm = im; dest_idx = di;
        e_tk = 0; e_tr = 0; e_mv = 0; e_an = 0; e_ln = 0; e_ix = 0; rq = "R10";
        if (v) begin
            case (c)
                1: begin e_tk = (a == b); rq = "R1"; end
                2: begin e_tk = (a != b); rq = "R1"; end
                3: begin e_tk = ($signed(a) >= 0); rq = "R2"; end
                4: begin e_tk = ($signed(a) > 0);  rq = "R2"; end
                5: begin e_tk = ($signed(a) <= 0); rq = "R2"; end
                6: begin e_tk = ($signed(a) < 0);  rq = "R2"; end
                7: begin e_tk = ($signed(a) >= 0); e_ln = 1; e_ix = 31; rq = "R3"; end
                8: begin e_tk = ($signed(a) < 0);  e_ln = 1; e_ix = 31; rq = "R3"; end
                9: begin e_tk = 1; e_ln = 1; e_ix = (di == 0) ? 5'd31 : di; rq = "R4"; end
                10: begin e_tr = rel(0, a, b, 0); rq = "R5"; end
                11: begin e_tr = rel(1, a, b, 0); rq = "R5"; end
                12: begin e_tr = rel(2, a, b, 0); rq = "R5"; end
                13: begin e_tr = rel(2, a, b, 1); rq = "R5"; end
                14: begin e_tr = rel(3, a, b, 0); rq = "R5"; end
                15: begin e_tr = rel(3, a, b, 1); rq = "R5"; end
                16: begin e_tr = rel(0, a, im, 0); rq = "R6"; end
                17: begin e_tr = rel(1, a, im, 0); rq = "R6"; end
                18: begin e_tr = rel(2, a, im, 0); rq = "R6"; end
                19: begin e_tr = rel(2, a, im, 1); rq = "R6"; end
                20: begin e_tr = rel(3, a, im, 0); rq = "R6"; end
                21: begin e_tr = rel(3, a, im, 1); rq = "R6"; end
                22: begin e_mv = (b != 0); rq = "R7"; end
                23: begin e_mv = (b == 0); rq = "R7"; end
                default: ;
            endcase
            if (c >= 1 && c <= 8) e_an = lk && !e_tk;
        end
        @(negedge clk);
        chk("R9",  32'(out_valid), 32'(v));
        chk(rq,    32'(taken),     32'(e_tk));
        chk(rq,    32'(trap_req),  32'(e_tr));
        chk(rq,    32'(move_en),   32'(e_mv));
        chk("R8",  32'(annul),     32'(e_an));
        chk(rq,    32'(link_en),   32'(e_ln));
        chk(rq,    32'(link_idx),  32'(e_ix));
        in_valid = 0;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", {26'd0, out_valid, taken, trap_req, move_en, annul, link_en}, 32'd0);
        chk("R10", 32'(link_idx), 32'd0);
        rst_n = 1;
        // R1..R8: all codes over the operand grid, both likely settings
        for (int c = 0; c < 32; c++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(1'b1, c, 1'(j % 2), vals[i], vals[j], vals[7 - j], 5'(j * 3));
        // R4: dest_idx 0 and non-zero
        apply(1'b1, 9, 0, 0, 0, 0, 5'd0);
        apply(1'b1, 9, 0, 0, 0, 0, 5'd17);
        // R10: strobe low with a code that would fire
        for (int c = 1; c < 24; c++)
            apply(1'b0, c, 1'b1, 0, 0, 0, 5'd5);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule